// File: doc/BRIEF.md
# Prescaled One-Shot Interval Timer

This block is a one-shot interval timer that software drives through two 16-bit registers. The configuration register sets a prescaler and a timeout. The prescaler divides the core clock by a power of two, and the timeout is a 12-bit limit on the count of prescaled ticks. The control register holds three things:

- an enable bit, which starts the timer;
- a done flag, which is read-only;
- a halt-enable bit.

Writing 1 to the enable bit clears the done flag and zeroes the prescaler and the tick counter. The timer then counts prescaled ticks. On the tick at which the count equals the timeout, the done flag sets and the enable bit clears by itself.

While the timer runs and halt-enable is set, the block asserts a halt request output. A processor uses it to stall itself for exactly the timed interval. The request drops on the same edge at which the done flag rises. The register port is a single-cycle write strobe with a one-bit register select. Reads are combinational from the selected register.

Top module: `interval_timer`

## Requirements
- R1: After reset, both registers read 0x0000 and haltReq is low.
- R2: The configuration register (regAddr = 1) reads back the value last written. Bits 15:12 are the prescaler select N and bits 11:0 are the timeout T.
- R3: A control write (regAddr = 0) with bit 14 set starts the timer. From the next cycle, bit 14 reads 1 and the done flag in bit 15 reads 0.
- R4: The done flag rises exactly (T+1)·2^N clock edges after the edge that accepted the start write. Bit 14 clears on that same edge.
- R5: With N = 0 and T = 0, the timer completes on the first edge after the start edge.
- R6: The done flag stays set until the next start, and it never reads 1 while bit 14 reads 1.
- R7: haltReq equals control bit 0 AND the running state. With bit 0 set, haltReq is high for exactly the (T+1)·2^N cycles of the interval. With bit 0 clear, it never rises.
- R8: A start write while the timer is running restarts the prescaler and the counter. The interval is measured afresh from that write.
- R9: On control writes, bits 15 and 13:1 are ignored, and so is a 0 in bit 14: a running timer keeps running. Bits 13:1 read as 0 and bit 0 reads back as written.
- R10: The largest select, N = 15, divides by 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 1 | Register select: 0 = control, 1 = configuration |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data from the selected register |
| haltReq | output | 1 | Processor halt request during the interval |

## Verification
Every cycle, the assertions check that:
- the done flag and the running state are never both set;
- the done flag rises only out of a running interval, and haltReq is already low on that edge;
- after a start strobe, the tick counter and the prescaler are both zero;
- the counter steps by at most one per cycle.

The exact interval length for several prescaler and timeout pairs, the halt window width, the restart timing and the ignored write fields can only be shown by the bench's directed scenarios. Each of these is timed from the accepting edge and observed through the register port and haltReq.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_CFG  = 1'b1
  } regSel_e;

  localparam int DONE_BIT = 15;
  localparam int ENA_BIT  = 14;
  localparam int HALT_BIT = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic run;
    logic cfgWr;
  } ctlStrobe_t;

endpackage

// File: rtl/itimer_ctrl.sv
module itimer_ctrl
  import itimer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expire,
  output ctlStrobe_t        strobes,
  output logic              running,
  output logic              done,
  output logic              haltEn,
  output logic              haltReq
);

  logic ctrlWr;
  logic startReq;

  assign ctrlWr   = wrEn && (wrAddr == REG_CTRL);
  assign startReq = ctrlWr && wrData[ENA_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      done    <= 1'b0;
      haltEn  <= 1'b0;
    end else begin
      if (ctrlWr) haltEn <= wrData[HALT_BIT];
      if (startReq) begin
        running <= 1'b1;
        done    <= 1'b0;
      end else if (expire) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.restart = startReq;
    strobes.run     = running;
    strobes.cfgWr   = wrEn && (wrAddr == REG_CFG);
  end

  assign haltReq = haltEn && running;

  // R6
  done_run_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && running));

  // R4
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(running));

  // R7
  halt_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !haltReq);

endmodule

// File: rtl/itimer_dp.sv
module itimer_dp
  import itimer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PS_W   = 4,
  parameter int TO_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [PS_W-1:0]   presSel,
  output logic [TO_W-1:0]   timeout,
  output logic              expire
);

  localparam int PRESC_W = (1 << PS_W) - 1;

  logic [PRESC_W-1:0] prescCnt;
  logic [PRESC_W-1:0] prescMask;
  logic [TO_W-1:0]    tickCnt;
  logic               tick;

  assign prescMask = ~({PRESC_W{1'b1}} << presSel);
  assign tick      = strobes.run && ((prescCnt & prescMask) == prescMask);
  assign expire    = tick && (tickCnt == timeout);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presSel <= '0;
      timeout <= '0;
    end else if (strobes.cfgWr) begin
      presSel <= wrData[TO_W +: PS_W];
      timeout <= wrData[TO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescCnt <= '0;
      tickCnt  <= '0;
    end else if (strobes.restart) begin
      prescCnt <= '0;
      tickCnt  <= '0;
    end else if (strobes.run) begin
      prescCnt <= tick ? '0 : prescCnt + 1'b1;
      if (tick && !expire) tickCnt <= tickCnt + 1'b1;
    end
  end

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (tickCnt == '0) && (prescCnt == '0));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.restart |=> (tickCnt == $past(tickCnt)) || (tickCnt == $past(tickCnt) + 1'b1));

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itimer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PS_W   = 4,
  parameter int TO_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              haltReq
);

  ctlStrobe_t      strobes;
  logic            expire;
  logic            running;
  logic            done;
  logic            haltEn;
  logic [PS_W-1:0] presSel;
  logic [TO_W-1:0] timeout;

  itimer_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrAddr(regAddr),
    .wrData(regWrData), .expire(expire), .strobes(strobes),
    .running(running), .done(done), .haltEn(haltEn), .haltReq(haltReq)
  );

  itimer_dp #(.DATA_W(DATA_W), .PS_W(PS_W), .TO_W(TO_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .presSel(presSel), .timeout(timeout), .expire(expire)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr == REG_CFG) begin
      regRdData[TO_W +: PS_W] = presSel;
      regRdData[TO_W-1:0]     = timeout;
    end else begin
      regRdData[DONE_BIT] = done;
      regRdData[ENA_BIT]  = running;
      regRdData[HALT_BIT] = haltEn;
    end
  end

endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        haltReq;

  int checks = 0;
  int fails  = 0;
  int cycleCnt = 0;

  interval_timer dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .haltReq(haltReq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycleCnt);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic addr, input logic [15:0] data);
    @(negedge clk);
    regAddr = addr; regWrData = data; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0; regAddr = 1'b0;
  endtask

  task automatic readReg(input logic addr, output logic [15:0] data);
    regAddr = addr; #1;
    data = regRdData;
    regAddr = 1'b0; #1;
  endtask

  // counts edges from the current point until done reads 1
  task automatic waitDone(inout int cycles, inout int haltCycles);
    regAddr = 1'b0; #1;
    while (!regRdData[15] && cycles < 100000) begin
      if (haltReq) haltCycles++;
      @(posedge clk); #1;
      cycles++;
    end
  endtask

  task automatic runInterval(input logic [3:0] sel, input logic [11:0] to,
                             input logic halt, output int cycles, output int haltCycles);
    writeReg(1'b1, {sel, to});
    writeReg(1'b0, {1'b0, 1'b1, 13'b0, halt});
    cycles = 0; haltCycles = 0;
    waitDone(cycles, haltCycles);
  endtask

  task automatic testReset();
    logic [15:0] d;
    readReg(1'b0, d); check("R1 ctrl", d, 16'h0000);
    readReg(1'b1, d); check("R1 cfg", d, 16'h0000);
    check("R1 halt", haltReq, 0);
  endtask

  task automatic testCfg();
    logic [15:0] d;
    writeReg(1'b1, 16'h7A5C);
    readReg(1'b1, d); check("R2 cfg readback", d, 16'h7A5C);
    writeReg(1'b1, 16'h0FFF);
    readReg(1'b1, d); check("R2 cfg readback", d, 16'h0FFF);
  endtask

  task automatic testStartFlags();
    logic [15:0] d;
    writeReg(1'b1, {4'd1, 12'd4});
    writeReg(1'b0, 16'h4000);
    readReg(1'b0, d);
    check("R3 enable set", d[14], 1);
    check("R3 done clear", d[15], 0);
  endtask

  task automatic testBasic();
    int c, h;
    logic [15:0] d;
    runInterval(4'd0, 12'd5, 1'b1, c, h);
    check("R4 interval N0 T5", c, 6);
    check("R7 halt width", h, 6);
    readReg(1'b0, d);
    check("R6 done held, enable cleared", d, 16'h8001);
    check("R7 halt low after done", haltReq, 0);
    repeat (5) @(posedge clk);
    #1;
    readReg(1'b0, d);
    check("R6 done still held", d[15], 1);
  endtask

  task automatic testPrescaled();
    int c, h;
    runInterval(4'd3, 12'd2, 1'b0, c, h);
    check("R4 interval N3 T2", c, 24);
    check("R7 no halt when disabled", h, 0);
    runInterval(4'd2, 12'd6, 1'b1, c, h);
    check("R4 interval N2 T6", c, 28);
    check("R7 halt width N2 T6", h, 28);
  endtask

  task automatic testZero();
    int c, h;
    runInterval(4'd0, 12'd0, 1'b1, c, h);
    check("R5 zero timeout", c, 1);
    check("R5 zero timeout halt", h, 1);
  endtask

  task automatic testMaxSel();
    int c, h;
    runInterval(4'd15, 12'd0, 1'b0, c, h);
    check("R10 select 15", c, 32768);
  endtask

  task automatic testRestart();
    int c, h;
    writeReg(1'b1, {4'd0, 12'd9});
    writeReg(1'b0, 16'h4000);
    repeat (3) @(posedge clk);
    #1;
    writeReg(1'b0, 16'h4000);
    c = 0; h = 0;
    waitDone(c, h);
    check("R8 restart interval", c, 10);
  endtask

  task automatic testIgnored();
    int c, h;
    logic [15:0] d;
    writeReg(1'b0, 16'hBFFE);
    readReg(1'b0, d);
    check("R9 ignored bits after done", d, 16'h8000);
    writeReg(1'b1, {4'd0, 12'd5});
    writeReg(1'b0, 16'h4001);
    c = 0;
    @(posedge clk); #1; c++;
    writeReg(1'b0, 16'h0001);
    c++;
    readReg(1'b0, d);
    check("R9 enable 0 ignored", d, 16'h4001);
    h = 0;
    waitDone(c, h);
    check("R9 interval unchanged", c, 6);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testCfg();
    testStartFlags();
    testBasic();
    testPrescaled();
    testZero();
    testRestart();
    testIgnored();
    testMaxSel();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule